// File: doc/BRIEF.md
# DRAM Rank Low-Power State Controller

This block follows a single DRAM rank and decides when it drops into a low-power state and when it must come back out. The three low-power states are active power-down, precharge power-down and self-refresh. The block is fed abstract event strobes from the command scheduler: scheduling and completion of bursts, precharges and refreshes, a refresh about to start, and an access that must be issued. It also sees status inputs: which banks are open, the rank's read and write queue occupancy, and the bus direction. It issues one-cycle requests to enter or leave power-down or self-refresh, and raises a drain-idle flag when the rank is quiet.

A saturating counter tracks outstanding command events. Activates are not counted, because the burst that follows each activate already covers it. A low-power state can be entered only when that counter, after the current cycle's updates, is zero. The state chosen depends on which completion event fired and, after a refresh, on the state the rank was in before the refresh began. The only way into self-refresh is a refresh that completes while the rank was in precharge power-down with nothing queued.

States, with their `pwr_state` code:

| State | Code |
|---|---|
| IDLE | 0 |
| ACT | 1 |
| PRE_PDN | 2 |
| ACT_PDN | 3 |
| SREF | 4 |
| REF | 5 |

Named transitions:

| Name | From | To |
|---|---|---|
| track | IDLE or ACT | ACT if any bank is open, otherwise IDLE |
| rd-entry | IDLE or ACT | ACT_PDN or PRE_PDN |
| pre-entry | IDLE or ACT | PRE_PDN |
| ref-begin | IDLE, ACT or a power-down state | REF |
| wake | power-down state | IDLE or ACT |
| ref-end | REF | PRE_PDN, SREF, IDLE or ACT |
| sref-leave | SREF | IDLE |

Top module: `dram_rank_pwr_ctrl`

## Requirements
- R1: `pending_evts` counts the schedule strobes (`sched_burst`, `sched_pre`, `sched_ref`) minus the completion strobes (`done_rd`, `done_wr`, `done_pre`, `done_ref`). It updates one cycle after the strobes, and a schedule and a completion in the same cycle cancel.
- R2: If an update would take the count below zero or above 2^CNT_W-1, `evt_err` pulses in the next cycle and the count keeps its old value.
- R3: rd-entry and pre-entry happen only when the count after the current cycle's update is zero and both `rdq_cnt` and `wrq_cnt` are zero. Otherwise the state follows the track transition.
- R4: `done_rd` in IDLE or ACT with at least one bank open and R3 satisfied moves the state to ACT_PDN (3). The next cycle shows `pd_enter`=1 and `pd_enter_act`=1.
- R5: `done_rd` with all banks closed and R3 satisfied moves the state to PRE_PDN (2). The next cycle shows `pd_enter`=1 and `pd_enter_act`=0.
- R6: `done_pre` with all banks closed and R3 satisfied moves the state to PRE_PDN with `pd_enter`=1. If any bank is open, no entry happens.
- R7: `ref_start` in a power-down state pulses `pd_exit` and moves the state to REF (5). In IDLE or ACT it moves the state to REF with no exit pulse. `ref_start` takes priority over every other event.
- R8: `done_ref` in REF, with a zero count after the update, depends on the state before the refresh. From ACT_PDN it enters PRE_PDN. From PRE_PDN with work queued it enters PRE_PDN. From PRE_PDN with nothing queued it enters SREF (4) and pulses `sref_enter`.
- R9: `done_ref` in REF from any other prior state, or with a nonzero count, returns to ACT if any bank is open and to IDLE otherwise.
- R10: `access_req` in a power-down state pulses `pd_exit` and moves the state to ACT if any bank is open, otherwise to IDLE.
- R11: In SREF, a nonzero `rdq_cnt`, or a nonzero `wrq_cnt` while `bus_write`=1, pulses `sref_exit` and moves the state to IDLE. Write-queue work while `bus_write`=0 leaves the state in SREF.
- R12: `drain_idle` is 1 only when the state is IDLE and no bank is open.
- R13: After reset the state is IDLE, the count is zero and every request output is 0. At most one of `pd_enter`, `pd_exit`, `sref_enter` and `sref_exit` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_burst | input | 1 | A read or write burst was scheduled |
| sched_pre | input | 1 | A precharge was scheduled |
| sched_ref | input | 1 | A refresh was scheduled |
| done_rd | input | 1 | Read data returned (burst complete) |
| done_wr | input | 1 | Write burst complete |
| done_pre | input | 1 | Precharge complete |
| done_ref | input | 1 | Refresh complete |
| ref_start | input | 1 | A refresh is about to start |
| access_req | input | 1 | A read or write must be issued to the rank |
| banks_open | input | NUM_BANKS | Per-bank open flag |
| rdq_cnt | input | Q_W | Read-queue entries for this rank |
| wrq_cnt | input | Q_W | Write-queue entries for this rank |
| bus_write | input | 1 | Bus is in write mode |
| pwr_state | output | 3 | Current power state code |
| pd_enter | output | 1 | Power-down entry request |
| pd_enter_act | output | 1 | Entry is active (1) or precharge (0) power-down |
| pd_exit | output | 1 | Power-down exit request |
| sref_enter | output | 1 | Self-refresh entry request |
| sref_exit | output | 1 | Self-refresh exit request |
| drain_idle | output | 1 | Rank is idle with all banks closed |
| pending_evts | output | CNT_W | Outstanding command events |
| evt_err | output | 1 | Counter underflow or overflow attempt |

## Verification
The bench targets entry on the very completion that empties the counter. A design that tested the registered count instead of the updated one would never power down on a read return. It sweeps bank status, queue contents and a leftover event across both completion types. A design that ignored the queues or the bank status there would park a busy rank in the wrong power-down state.

Refresh is exercised from every prior state. A controller that lost the pre-refresh state, or that allowed self-refresh with queued work, would land in the wrong state. The self-refresh exit sweep covers all queue and bus combinations, which exposes a design that wakes on write work while the bus is reading. Counter tests at both ends check that an underflow or overflow is flagged without corrupting the count, and that a simultaneous schedule and completion at the ceiling is not flagged.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_ACT     = 3'd1,
        PS_PRE_PDN = 3'd2,
        PS_ACT_PDN = 3'd3,
        PS_SREF    = 3'd4,
        PS_REF     = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic pd_enter;
        logic pd_act;
        logic pd_exit;
        logic sr_enter;
        logic sr_exit;
    } pwr_req_t;

endpackage

// File: rtl/rank_evt_counter.sv
module rank_evt_counter #(
    parameter int CNT_W   = 4,
    parameter int N_SCHED = 3,
    parameter int N_DONE  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SCHED-1:0] sched,
    input  logic [N_DONE-1:0]  done,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   cnt_nxt,
    output logic               err
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    int  sum;
    logic bad;

    always_comb begin
        sum     = int'(cnt) + $countones(sched) - $countones(done);
        bad     = (sum < 0) || (sum > CNT_MAX);
        cnt_nxt = bad ? cnt : CNT_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            err <= bad;
        end
    end
endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
    import rank_pwr_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int Q_W       = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_zero,
    input  logic                 done_rd,
    input  logic                 done_pre,
    input  logic                 done_ref,
    input  logic                 ref_start,
    input  logic                 access_req,
    input  logic [NUM_BANKS-1:0] banks_open,
    input  logic [Q_W-1:0]       rdq_cnt,
    input  logic [Q_W-1:0]       wrq_cnt,
    input  logic                 bus_write,
    output pwr_state_e           state,
    output pwr_req_t             req
);
    pwr_state_e state_nxt, prior, prior_nxt;
    pwr_req_t   req_nxt;
    logic       any_open, q_empty, sr_wake;
    pwr_state_e awake;

    always_comb begin
        any_open = |banks_open;
        q_empty  = (rdq_cnt == '0) && (wrq_cnt == '0);
        sr_wake  = (rdq_cnt != '0) || ((wrq_cnt != '0) && bus_write);
        awake    = any_open ? PS_ACT : PS_IDLE;
    end

    always_comb begin
        state_nxt = state;
        prior_nxt = prior;
        req_nxt   = '0;
        unique case (state)
            PS_IDLE, PS_ACT: begin
                if (ref_start) begin
                    state_nxt = PS_REF;
                    prior_nxt = state;
                end else if (done_rd && cnt_zero && q_empty) begin
                    req_nxt.pd_enter = 1'b1;
                    req_nxt.pd_act   = any_open;
                    state_nxt        = any_open ? PS_ACT_PDN : PS_PRE_PDN;
                end else if (done_pre && cnt_zero && q_empty && !any_open) begin
                    req_nxt.pd_enter = 1'b1;
                    state_nxt        = PS_PRE_PDN;
                end else begin
                    state_nxt = awake;
                end
            end
            PS_ACT_PDN, PS_PRE_PDN: begin
                if (ref_start) begin
                    req_nxt.pd_exit = 1'b1;
                    state_nxt       = PS_REF;
                    prior_nxt       = state;
                end else if (access_req) begin
                    req_nxt.pd_exit = 1'b1;
                    state_nxt       = awake;
                end
            end
            PS_REF: begin
                if (done_ref) begin
                    if (cnt_zero && prior == PS_ACT_PDN) begin
                        req_nxt.pd_enter = 1'b1;
                        state_nxt        = PS_PRE_PDN;
                    end else if (cnt_zero && prior == PS_PRE_PDN) begin
                        if (q_empty) begin
                            req_nxt.sr_enter = 1'b1;
                            state_nxt        = PS_SREF;
                        end else begin
                            req_nxt.pd_enter = 1'b1;
                            state_nxt        = PS_PRE_PDN;
                        end
                    end else begin
                        state_nxt = awake;
                    end
                end
            end
            PS_SREF: begin
                if (sr_wake) begin
                    req_nxt.sr_exit = 1'b1;
                    state_nxt       = PS_IDLE;
                end
            end
            default: state_nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            prior <= PS_IDLE;
        end else begin
            state <= state_nxt;
            prior <= prior_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req <= '0;
        else        req <= req_nxt;
    end
endmodule

// File: rtl/dram_rank_pwr_ctrl.sv
module dram_rank_pwr_ctrl
    import rank_pwr_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int Q_W       = 6,
    parameter int CNT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sched_burst,
    input  logic                 sched_pre,
    input  logic                 sched_ref,
    input  logic                 done_rd,
    input  logic                 done_wr,
    input  logic                 done_pre,
    input  logic                 done_ref,
    input  logic                 ref_start,
    input  logic                 access_req,
    input  logic [NUM_BANKS-1:0] banks_open,
    input  logic [Q_W-1:0]       rdq_cnt,
    input  logic [Q_W-1:0]       wrq_cnt,
    input  logic                 bus_write,
    output logic [2:0]           pwr_state,
    output logic                 pd_enter,
    output logic                 pd_enter_act,
    output logic                 pd_exit,
    output logic                 sref_enter,
    output logic                 sref_exit,
    output logic                 drain_idle,
    output logic [CNT_W-1:0]     pending_evts,
    output logic                 evt_err
);
    logic [CNT_W-1:0] cnt_nxt;
    pwr_state_e       st;
    pwr_req_t         rq;

    rank_evt_counter #(.CNT_W(CNT_W), .N_SCHED(3), .N_DONE(4)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sched   ({sched_burst, sched_pre, sched_ref}),
        .done    ({done_rd, done_wr, done_pre, done_ref}),
        .cnt     (pending_evts),
        .cnt_nxt (cnt_nxt),
        .err     (evt_err)
    );

    rank_pwr_fsm #(.NUM_BANKS(NUM_BANKS), .Q_W(Q_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_zero   (cnt_nxt == '0),
        .done_rd    (done_rd),
        .done_pre   (done_pre),
        .done_ref   (done_ref),
        .ref_start  (ref_start),
        .access_req (access_req),
        .banks_open (banks_open),
        .rdq_cnt    (rdq_cnt),
        .wrq_cnt    (wrq_cnt),
        .bus_write  (bus_write),
        .state      (st),
        .req        (rq)
    );

    assign pwr_state    = 3'(st);
    assign pd_enter     = rq.pd_enter;
    assign pd_enter_act = rq.pd_act;
    assign pd_exit      = rq.pd_exit;
    assign sref_enter   = rq.sr_enter;
    assign sref_exit    = rq.sr_exit;
    assign drain_idle   = (st == PS_IDLE) && !(|banks_open);
endmodule

// File: rtl/rank_pwr_checker.sv
module rank_pwr_checker
    import rank_pwr_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int Q_W       = 6,
    parameter int CNT_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           pwr_state,
    input logic                 pd_enter,
    input logic                 pd_exit,
    input logic                 sref_enter,
    input logic                 sref_exit,
    input logic                 drain_idle,
    input logic [CNT_W-1:0]     pending_evts,
    input logic                 evt_err
);
    a_r3_entry_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_enter || sref_enter) |-> (pending_evts == '0));

    a_r2_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> (pending_evts == $past(pending_evts)));

    a_r8_sref_via_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'(PS_SREF) && $past(pwr_state) != 3'(PS_SREF))
            |-> ($past(pwr_state) == 3'(PS_REF)));

    a_r10_exit_from_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        pd_exit |-> ($past(pwr_state) == 3'(PS_ACT_PDN) ||
                     $past(pwr_state) == 3'(PS_PRE_PDN)));

    a_r11_sref_leave: assert property (@(posedge clk) disable iff (!rst_n)
        sref_exit |-> ($past(pwr_state) == 3'(PS_SREF) && pwr_state == 3'(PS_IDLE)));

    a_r12_no_drain_lowpwr: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'(PS_IDLE)) |-> !drain_idle);

    a_r13_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_enter, pd_exit, sref_enter, sref_exit}));

    a_r13_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state <= 3'd5);
endmodule

bind dram_rank_pwr_ctrl rank_pwr_checker #(
    .NUM_BANKS(NUM_BANKS), .Q_W(Q_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/test_dram_rank_pwr_ctrl.sv
module test_dram_rank_pwr_ctrl;
    localparam int NB = 8;
    localparam int QW = 6;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic sched_burst, sched_pre, sched_ref;
    logic done_rd, done_wr, done_pre, done_ref;
    logic ref_start, access_req, bus_write;
    logic [NB-1:0] banks_open;
    logic [QW-1:0] rdq_cnt, wrq_cnt;
    logic [2:0] pwr_state;
    logic pd_enter, pd_enter_act, pd_exit, sref_enter, sref_exit, drain_idle, evt_err;
    logic [CW-1:0] pending_evts;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dram_rank_pwr_ctrl #(.NUM_BANKS(NB), .Q_W(QW), .CNT_W(CW)) i_dram_rank_pwr_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_strobes();
        {sched_burst, sched_pre, sched_ref} = '0;
        {done_rd, done_wr, done_pre, done_ref} = '0;
        ref_start = 0;
        access_req = 0;
    endtask

    task automatic do_reset();
        clr_strobes();
        banks_open = '0; rdq_cnt = '0; wrq_cnt = '0; bus_write = 0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic go_pdn(input logic bo);
        banks_open = bo ? NB'(1) : '0;
        sched_burst = 1; tick(); clr_strobes();
        done_rd = 1; tick(); clr_strobes();
    endtask

    task automatic go_sref();
        do_reset();
        go_pdn(0);
        ref_start = 1; tick(); clr_strobes();
        sched_ref = 1; tick(); clr_strobes();
        done_ref = 1; tick(); clr_strobes();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R13 reset state
        chk("R13 state", pwr_state, 0);
        chk("R13 count", pending_evts, 0);
        chk("R13 reqs", {pd_enter, pd_exit, sref_enter, sref_exit}, 0);
        chk("R12 drain idle", drain_idle, 1);

        // R1 counting and cancel
        {sched_burst, sched_pre, sched_ref} = 3'b111; tick(); clr_strobes();
        chk("R1 plus three", pending_evts, 3);
        sched_burst = 1; done_wr = 1; tick(); clr_strobes();
        chk("R1 cancel", pending_evts, 3);
        done_wr = 1; done_pre = 1; tick(); clr_strobes();
        chk("R1 minus two", pending_evts, 1);

        // R2 underflow and overflow
        do_reset();
        done_wr = 1; tick(); clr_strobes();
        chk("R2 underflow flag", evt_err, 1);
        chk("R2 underflow hold", pending_evts, 0);
        for (int i = 0; i < 5; i++) begin
            {sched_burst, sched_pre, sched_ref} = 3'b111; tick(); clr_strobes();
        end
        chk("R2 full", pending_evts, 15);
        sched_burst = 1; done_wr = 1; tick(); clr_strobes();
        chk("R2 cancel at top", evt_err, 0);
        sched_burst = 1; sched_pre = 1; done_wr = 1; tick(); clr_strobes();
        chk("R2 overflow flag", evt_err, 1);
        chk("R2 overflow hold", pending_evts, 15);

        // R3 R4 R5 read-return sweep
        for (int extra = 0; extra < 2; extra++)
            for (int bo = 0; bo < 2; bo++)
                for (int q = 0; q < 3; q++) begin
                    bit ent;
                    do_reset();
                    banks_open = bo ? NB'(2) : '0;
                    rdq_cnt = (q == 1) ? QW'(1) : '0;
                    wrq_cnt = (q == 2) ? QW'(3) : '0;
                    sched_burst = 1; tick(); clr_strobes();
                    if (extra == 1) begin sched_pre = 1; tick(); clr_strobes(); end
                    done_rd = 1; tick(); clr_strobes();
                    ent = (extra == 0) && (q == 0);
                    chk("R3 entry gate", pd_enter, int'(ent));
                    chk(bo ? "R4 state" : "R5 state", pwr_state,
                        ent ? (bo ? 3 : 2) : bo);
                    chk(bo ? "R4 act flag" : "R5 act flag", pd_enter_act, int'(ent && bo));
                    chk("R1 residue", pending_evts, extra);
                end

        // R6 precharge-complete sweep
        for (int bo = 0; bo < 2; bo++)
            for (int q = 0; q < 2; q++) begin
                bit ent;
                do_reset();
                banks_open = bo ? NB'(4) : '0;
                wrq_cnt = QW'(q);
                sched_pre = 1; tick(); clr_strobes();
                done_pre = 1; tick(); clr_strobes();
                ent = !bo && (q == 0);
                chk("R6 entry", pd_enter, int'(ent));
                chk("R6 state", pwr_state, ent ? 2 : bo);
            end

        // R7 R8 refresh from ACT_PDN
        do_reset();
        go_pdn(1);
        chk("R4 in ACT_PDN", pwr_state, 3);
        banks_open = '0;
        ref_start = 1; tick(); clr_strobes();
        chk("R7 exit pulse", pd_exit, 1);
        chk("R7 REF", pwr_state, 5);
        sched_ref = 1; tick(); clr_strobes();
        done_ref = 1; tick(); clr_strobes();
        chk("R8 ACT_PDN to PRE_PDN", pwr_state, 2);
        chk("R8 pd_enter", pd_enter, 1);
        chk("R12 no drain in pdn", drain_idle, 0);

        // R8 from PRE_PDN with queued work
        ref_start = 1; tick(); clr_strobes();
        rdq_cnt = 2;
        sched_ref = 1; tick(); clr_strobes();
        done_ref = 1; tick(); clr_strobes();
        chk("R8 queued stays PRE_PDN", pwr_state, 2);
        chk("R8 no sref", sref_enter, 0);

        // R8 into SREF
        go_sref();
        chk("R8 SREF", pwr_state, 4);
        chk("R8 sref_enter", sref_enter, 1);

        // R9 refresh from IDLE, and with leftover count
        do_reset();
        ref_start = 1; tick(); clr_strobes();
        chk("R7 no exit from IDLE", pd_exit, 0);
        chk("R7 REF from IDLE", pwr_state, 5);
        done_ref = 1; sched_ref = 1; tick(); clr_strobes();
        done_ref = 1; tick(); clr_strobes();
        chk("R9 back to IDLE", pwr_state, 0);
        do_reset();
        go_pdn(0);
        ref_start = 1; tick(); clr_strobes();
        sched_ref = 1; sched_burst = 1; tick(); clr_strobes();
        done_ref = 1; tick(); clr_strobes();
        chk("R9 count blocks entry", pwr_state, 0);

        // R10 wake on access
        do_reset();
        go_pdn(1);
        access_req = 1; tick(); clr_strobes();
        chk("R10 exit pulse", pd_exit, 1);
        chk("R10 to ACT", pwr_state, 1);
        do_reset();
        go_pdn(0);
        access_req = 1; tick(); clr_strobes();
        chk("R10 to IDLE", pwr_state, 0);
        do_reset();
        go_pdn(0);
        access_req = 1; ref_start = 1; tick(); clr_strobes();
        chk("R7 priority", pwr_state, 5);

        // R11 self-refresh exit sweep
        for (int r = 0; r < 2; r++)
            for (int w = 0; w < 2; w++)
                for (int b = 0; b < 2; b++) begin
                    bit ex;
                    go_sref();
                    rdq_cnt = QW'(r); wrq_cnt = QW'(w * 5); bus_write = b[0];
                    tick();
                    ex = (r != 0) || (w != 0 && b != 0);
                    chk("R11 exit pulse", sref_exit, int'(ex));
                    chk("R11 state", pwr_state, ex ? 0 : 4);
                end

        // R12 drain with open bank
        do_reset();
        banks_open = 8'h80; tick();
        chk("R12 ACT", pwr_state, 1);
        chk("R12 no drain open", drain_idle, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule